// File: doc/BRIEF.md
# Port Pin-Change Interrupt Unit

This block watches an eight-pin input port and records a pending event for any pin that makes a chosen transition. Every pin has three configuration bits of its own: a polarity bit that selects whether a low-to-high or a high-to-low transition counts, a sticky event flag, and a request enable. Software writes these bits through a small write port.

The enabled flags are combined into one maskable request line. That line is qualified by a global enable input that comes from the processor. A registered index output names the lowest-numbered pin whose flag and enable are both set, so a service routine can go straight to that pin.

Pins are asynchronous to the block clock. Each pin passes through a two-stage synchroniser before its transition is detected. Transition detection is held off for a short settling window after reset, so a pin that is already high when reset ends is not mistaken for an edge.

Top module: `pinchg_irq_top`

## Requirements
- R1: After reset all flags, polarity bits and enables are 0, `irq_o` is 0 and `pend_valid_o` is 0.
- R2: A pin transition that is driven before clock edge 1 appears in `flags_o` after clock edge 3, and not after edge 2.
- R3: Polarity bit 0 selects low-to-high and polarity bit 1 selects high-to-low. The opposite transition never sets the flag.
- R4: A set flag stays set, with no further pin activity, until software writes it.
- R5: Write addresses: 0 holds the polarity bits, 1 holds the flags (the written value replaces them, so 1 sets and 0 clears), and 2 holds the enables. A write to address 3 changes nothing.
- R6: If a detected transition and a software write of 0 to that flag fall in the same cycle, the flag ends up set.
- R7: Changing a polarity bit while the pin is steady does not set that pin's flag.
- R8: Flags latch whether or not the pin's enable is set.
- R9: `irq_o` is 1 exactly when `gie_i` is 1 and at least one pin has both its flag and its enable set. It follows the registered state with no added delay.
- R10: One cycle after the flag and enable state changes, `pend_idx_o` gives the lowest pin with both its flag and its enable set, and `pend_valid_o` is 1 when any such pin exists.
- R11: A pin that is held high through reset and stays high afterwards does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous port pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 polarity, 1 flags, 2 enables |
| wr_data_i | input | 8 | Write data, one bit per pin |
| gie_i | input | 1 | Global interrupt enable |
| flags_o | output | 8 | Current event flags |
| irq_o | output | 1 | Maskable interrupt request |
| pend_idx_o | output | 3 | Lowest pending enabled pin |
| pend_valid_o | output | 1 | Pending index is meaningful |

## Verification
The bench sweeps every pin under both polarities in both transition directions. It samples one edge before and one edge after the expected flag update, so a synchroniser that is one stage short or one stage long is caught, and so is a polarity decoder that is inverted or that fires on both edges. It times a software clear to land on the same edge as a detected transition; a design that lets the write win loses the event. It holds the port high through reset, where an ungated detector would report false rising edges. It also toggles polarity bits on steady pins, where a detector that compares against the polarity would raise spurious flags. All 256 flag patterns are written with varying enables and global enable, and the request and pending index are compared with an arithmetic model; a priority encoder that favours the highest pin, or an index that is not registered, shows up there.

// File: rtl/pc_pkg.sv
package pc_pkg;

    // Register select field decoded by the write port
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_POL  = 2'd0,
        REG_FLAG = 2'd1,
        REG_EN   = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Clock edges after reset before transition detection is trusted:
    // two synchroniser stages plus the history stage.
    localparam int ARM_STAGES = 3;

endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stab;

endmodule

// File: rtl/pc_edge.sv
module pc_edge #(
    parameter int N   = 8,
    parameter int ARM = pc_pkg::ARM_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] fall_sel_i,
    input  logic         flag_wr_i,
    input  logic [N-1:0] flag_wdata_i,
    output logic [N-1:0] flags_o
);

    typedef struct packed {
        logic [N-1:0]   hist;
        logic [ARM-1:0] arm;
        logic [N-1:0]   flag;
    } edge_st_t;

    edge_st_t     st_d, st_q;
    logic [N-1:0] hit;
    logic         armed;

    // One detector per pin; each watches a single chosen transition
    for (genvar g = 0; g < N; g++) begin : g_det
        always_comb begin
            if (fall_sel_i[g]) begin
                hit[g] = st_q.hist[g] & ~sync_i[g];
            end else begin
                hit[g] = ~st_q.hist[g] & sync_i[g];
            end
        end
    end

    assign armed = st_q.arm[ARM-1];

    always_comb begin
        logic [N-1:0] base;
        st_d      = st_q;
        st_d.hist = sync_i;
        st_d.arm  = {st_q.arm[ARM-2:0], 1'b1};
        base      = flag_wr_i ? flag_wdata_i : st_q.flag;
        // hardware detection wins over a same-cycle software clear
        st_d.flag = base | (armed ? hit : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flag;

endmodule

// File: rtl/pc_arb.sv
module pc_arb #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             valid;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.idx   = '0;
        st_d.valid = 1'b0;
        // scan downwards so the lowest requesting pin is the last to win
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                st_d.idx   = IDX_W'(i);
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o   = st_q.idx;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/pinchg_irq_top.sv
module pinchg_irq_top #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              pin_i,
    input  logic                      wr_en_i,
    input  logic [pc_pkg::ADDR_W-1:0] wr_addr_i,
    input  logic [N-1:0]              wr_data_i,
    input  logic                      gie_i,
    output logic [N-1:0]              flags_o,
    output logic                      irq_o,
    output logic [IDX_W-1:0]          pend_idx_o,
    output logic                      pend_valid_o
);

    import pc_pkg::*;

    typedef struct packed {
        logic [N-1:0] pol;
        logic [N-1:0] en;
    } cfg_st_t;

    cfg_st_t      cfg_d, cfg_q;
    logic [N-1:0] pin_sync;
    logic [N-1:0] pin_en;
    logic [N-1:0] req_vec;
    logic         flag_wr;

    always_comb begin
        cfg_d   = cfg_q;
        flag_wr = 1'b0;
        if (wr_en_i) begin
            unique case (reg_sel_e'(wr_addr_i))
                REG_POL:  cfg_d.pol = wr_data_i;
                REG_FLAG: flag_wr   = 1'b1;
                REG_EN:   cfg_d.en  = wr_data_i;
                REG_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    pc_sync #(.N(N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    pc_edge #(.N(N)) u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (pin_sync),
        .fall_sel_i   (cfg_q.pol),
        .flag_wr_i    (flag_wr),
        .flag_wdata_i (wr_data_i),
        .flags_o      (flags_o)
    );

    assign pin_en  = cfg_q.en;
    assign req_vec = flags_o & pin_en;
    assign irq_o   = gie_i & (|req_vec);

    pc_arb #(.N(N), .IDX_W(IDX_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_vec),
        .idx_o   (pend_idx_o),
        .valid_o (pend_valid_o)
    );

endmodule

// File: rtl/pc_chk.sv
module pc_chk #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             gie_i,
    input logic [N-1:0]     flags_o,
    input logic [N-1:0]     pin_en,
    input logic             irq_o,
    input logic [IDX_W-1:0] pend_idx_o,
    input logic             pend_valid_o
);

    logic [N-1:0] prev_req_q;
    logic [N-1:0] below_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_req_q <= '0;
        end else begin
            prev_req_q <= flags_o & pin_en;
        end
    end

    assign below_mask = (N'(1) << pend_idx_o) - N'(1);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> !irq_o);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((~flags_o & $past(flags_o)) == '0));

    // R10
    pend_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o == (|prev_req_q));

    // R10
    pend_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> prev_req_q[pend_idx_o]);

    // R10
    pend_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> ((prev_req_q & below_mask) == '0));

endmodule

bind pinchg_irq_top pc_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .gie_i        (gie_i),
    .flags_o      (flags_o),
    .pin_en       (pin_en),
    .irq_o        (irq_o),
    .pend_idx_o   (pend_idx_o),
    .pend_valid_o (pend_valid_o)
);

// File: tb/sim_pinchg_irq_top.sv
module sim_pinchg_irq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       gie_i = 1'b0;
    logic [7:0] flags_o;
    logic       irq_o;
    logic [2:0] pend_idx_o;
    logic       pend_valid_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pinchg_irq_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .gie_i        (gie_i),
        .flags_o      (flags_o),
        .irq_o        (irq_o),
        .pend_idx_o   (pend_idx_o),
        .pend_valid_o (pend_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = a;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] pins);
        @(negedge clk);
        rst_n = 1'b0;
        pin_i = pins;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(8'h00);
        idle(1);
        chk(flags_o == 8'h00, "R1 flags", flags_o, 0);
        chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
        chk(pend_valid_o == 1'b0, "R1 valid", pend_valid_o, 0);

        // R11 pins held high through reset
        do_reset(8'hFF);
        idle(8);
        chk(flags_o == 8'h00, "R11 held-high pins", flags_o, 0);
        do_reset(8'h00);
        idle(6);

        // R2 R3 sweep every pin and both polarities
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 2; s++) begin
                logic [7:0] bitm;
                bitm = 8'(1 << p);
                wr(2'd0, s ? bitm : 8'h00);
                wr(2'd1, 8'h00);
                @(negedge clk);
                pin_i = bitm;
                idle(2);
                chk(flags_o == 8'h00, "R2 rise early", flags_o, 0);
                idle(1);
                chk(flags_o == (s == 0 ? bitm : 8'h00), "R3 rise", flags_o, s == 0 ? bitm : 0);
                wr(2'd1, 8'h00);
                @(negedge clk);
                pin_i = 8'h00;
                idle(2);
                chk(flags_o == 8'h00, "R2 fall early", flags_o, 0);
                idle(1);
                chk(flags_o == (s == 1 ? bitm : 8'h00), "R3 fall", flags_o, s == 1 ? bitm : 0);
                // R4 flag holds
                idle(6);
                chk(flags_o == (s == 1 ? bitm : 8'h00), "R4 sticky", flags_o, s == 1 ? bitm : 0);
            end
        end

        // R6 hardware event on the same edge as a software clear
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        @(negedge clk);
        pin_i = 8'h08;
        idle(2);
        wr_en_i   = 1'b1;
        wr_addr_i = 2'd1;
        wr_data_i = 8'h00;
        @(negedge clk);
        wr_en_i = 1'b0;
        chk(flags_o == 8'h08, "R6 event beats clear", flags_o, 8'h08);
        @(negedge clk);
        pin_i = 8'h00;
        idle(4);

        // R7 polarity changes on steady pins
        @(negedge clk);
        pin_i = 8'h5A;
        idle(5);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
        idle(4);
        wr(2'd0, 8'h0F);
        idle(4);
        wr(2'd0, 8'h00);
        idle(4);
        chk(flags_o == 8'h00, "R7 polarity change", flags_o, 0);
        @(negedge clk);
        pin_i = 8'h00;
        idle(4);
        wr(2'd0, 8'h00);

        // R8 flag latches while disabled, no request
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        gie_i = 1'b1;
        @(negedge clk);
        pin_i = 8'h20;
        idle(4);
        chk(flags_o == 8'h20, "R8 latch when disabled", flags_o, 8'h20);
        chk(irq_o == 1'b0, "R8 no request", irq_o, 0);
        @(negedge clk);
        pin_i = 8'h00;
        idle(4);

        // R5 address 3 ignored, checked through flags and request
        wr(2'd1, 8'h01);
        wr(2'd3, 8'hFF);
        idle(1);
        chk(flags_o == 8'h01, "R5 addr3 flags", flags_o, 8'h01);
        chk(irq_o == 1'b0, "R5 addr3 enables", irq_o, 0);

        // R5 R9 R10 sweep every flag pattern
        for (int pat = 0; pat < 256; pat++) begin
            logic [7:0] en;
            logic [7:0] req;
            logic       g;
            int         low;
            en  = 8'(pat * 5 + 3);
            g   = (pat % 3) != 0;
            req = 8'(pat) & en;
            low = 0;
            for (int i = 7; i >= 0; i--) begin
                if (req[i]) low = i;
            end
            gie_i = g;
            wr(2'd2, en);
            wr(2'd1, 8'(pat));
            chk(flags_o == 8'(pat), "R5 flag write", flags_o, pat);
            chk(irq_o == (g & (req != 0)), "R9 request", irq_o, g & (req != 0));
            @(negedge clk);
            chk(pend_valid_o == (req != 0), "R10 valid", pend_valid_o, req != 0);
            if (req != 0) begin
                chk(pend_idx_o == 3'(low), "R10 index", pend_idx_o, low);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule